// File: doc/BRIEF.md
# Framed Three-Sample Moving Averager

This block smooths a stream of 8-bit unsigned samples. Each sample comes with a 2-bit tag that says whether the cycle is idle or carries the opening, an inner or the closing sample of a frame. For every tagged sample the block produces the mean of that sample and the two tagged samples before it. The tag travels with the result, so a consumer can see the frame boundaries without any extra timing logic.

A three-tap history line captures the samples. When a frame opens, the two older taps are forced to zero, so the history never reaches back into an earlier frame. A combinational adder sums the taps. Instead of dividing by three, the block multiplies by the constant 85 and keeps the bits above the low eight. An output register then stores the scaled mean together with the delayed tag. The result for a sample appears two clock edges after that sample is presented.

Top module: `tri_mean_filter`

## Requirements
- R1: A synchronous reset (rst_n low at a rising edge) clears mean_out, tag_out and all three history taps to zero. A middle-coded sample that follows reset directly therefore averages against two zero values.
- R2: Tag codes are fixed: 2'b00 idle, 2'b01 opening sample of a frame, 2'b10 inner sample, 2'b11 closing sample. Any non-idle code captures sample_in into the newest tap.
- R3: For taps a, b and c, the mean is floor((a+b+c)*85/256). The sum is 10 bits wide and the product at least 17 bits, so nothing overflows. The result never exceeds (a+b+c)/3, and it fits in 8 bits (255,255,255 gives 254).
- R4: An opening-coded sample loads zero into the two older taps in the same edge that captures the new sample. Its mean is therefore floor(s*85/256).
- R5: An idle cycle leaves every history tap unchanged. Inserting idle cycles inside a frame does not alter any later mean.
- R6: tag_out equals tag_in delayed by exactly two rising edges. The mean for the sample presented before edge k is on mean_out after edge k+1.
- R7: When the delayed tag is idle, tag_out is 2'b00 and mean_out keeps its previous value.
- R8: The tagged stream 100, 50, 200, 200, 200, 120 (tags 01, 10, 10, 10, 10, 11) yields the means 33, 49, 116, 149, 199, 172.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sample_in | input | 8 | Unsigned input sample |
| tag_in | input | 2 | Frame tag of sample_in |
| mean_out | output | 8 | Scaled three-sample mean |
| tag_out | output | 2 | Tag aligned with mean_out |

## Verification
Two events can land in the same cycle: a frame opening, which zero-fills the older taps, and the output stage, which is still emitting the mean of the previous frame's closing sample. The bench provokes this with back-to-back frames, where a closing tag is followed at once by an opening tag. The random stream also produces such pairs, and it mixes in idle cycles inside frames. Each output is judged against a reference that keeps its own zero-filled history and computes the mean with integer division rather than a bit shift. Both the tag and the mean are compared on every cycle, including idle cycles, where the mean must hold.

// File: rtl/fma_pkg.sv
`timescale 1ns/1ps
package fma_pkg;
  // number of samples in the averaging window
  localparam int TAPS = 3;

  // frame tag codes; the opening code drives the zero fill
  localparam logic [1:0] TAG_IDLE  = 2'b00;
  localparam logic [1:0] TAG_FIRST = 2'b01;
  localparam logic [1:0] TAG_MID   = 2'b10;
  localparam logic [1:0] TAG_LAST  = 2'b11;

  function automatic logic tag_valid(input logic [1:0] t);
    return t != TAG_IDLE;
  endfunction

  function automatic logic tag_opens(input logic [1:0] t);
    return t == TAG_FIRST;
  endfunction
endpackage

// File: rtl/fma_history.sv
`timescale 1ns/1ps
module fma_history
  import fma_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NTAPS  = TAPS
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [DATA_W-1:0]       sample_in,
  input  logic [1:0]              tag_in,
  output logic [NTAPS*DATA_W-1:0] taps_o
);
  localparam int OLD_W = (NTAPS - 1) * DATA_W;

  // named events for the checks below
  logic capture_w;
  logic open_w;
  assign capture_w = tag_valid(tag_in);
  assign open_w    = tag_opens(tag_in);

  logic [DATA_W-1:0] tap_q [NTAPS];

  genvar gi;
  generate
    for (gi = 0; gi < NTAPS; gi++) begin : g_tap
      if (gi == 0) begin : g_head
        always_ff @(posedge clk) begin
          if (!rst_n)         tap_q[gi] <= '0;
          else if (capture_w) tap_q[gi] <= sample_in;
        end
      end else begin : g_body
        always_ff @(posedge clk) begin
          if (!rst_n)         tap_q[gi] <= '0;
          else if (capture_w) tap_q[gi] <= open_w ? '0 : tap_q[gi-1];
        end
      end
      assign taps_o[gi*DATA_W +: DATA_W] = tap_q[gi];
    end
  endgenerate

  // armed once an edge outside reset has occurred
  logic armed_q;
  always_ff @(posedge clk) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  // R4: frame opening clears the older taps
  assert_zero_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && $past(tag_in) == TAG_FIRST) |-> (taps_o[NTAPS*DATA_W-1:DATA_W] == '0));

  // R2: any tagged cycle captures the sample into the newest tap
  assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && $past(tag_in) != TAG_IDLE) |-> (taps_o[DATA_W-1:0] == $past(sample_in)));

  // R5: idle cycles hold the history
  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && $past(tag_in) == TAG_IDLE) |-> $stable(taps_o));

  // opening shift: newest tap moves down only on non-opening samples
  assert_shift_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && $past(tag_in) != TAG_IDLE && $past(tag_in) != TAG_FIRST)
      |-> (taps_o[OLD_W +: DATA_W] == $past(taps_o[OLD_W-DATA_W +: DATA_W])));
endmodule

// File: rtl/fma_scale.sv
`timescale 1ns/1ps
module fma_scale
  import fma_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NTAPS  = TAPS,
  parameter int COEF   = 85,
  parameter int COEF_W = 7,
  parameter int SHIFT  = 8
) (
  input  logic [NTAPS*DATA_W-1:0]              taps_i,
  output logic [DATA_W+$clog2(NTAPS+1)-1:0]    sum_o,
  output logic [DATA_W-1:0]                    mean_o
);
  localparam int SUM_W  = DATA_W + $clog2(NTAPS + 1);
  localparam int PROD_W = SUM_W + COEF_W;

  // scale a window sum by COEF / 2^SHIFT, truncating toward zero
  function automatic logic [DATA_W-1:0] scale_sum(input logic [SUM_W-1:0] s);
    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] kept;
    prod = PROD_W'(s) * PROD_W'(COEF);
    kept = prod >> SHIFT;
    return DATA_W'(kept);
  endfunction

  always_comb begin
    sum_o = '0;
    for (int i = 0; i < NTAPS; i++) begin
      sum_o = sum_o + SUM_W'(taps_i[i*DATA_W +: DATA_W]);
    end
  end

  assign mean_o = scale_sum(sum_o);
endmodule

// File: rtl/tri_mean_filter.sv
`timescale 1ns/1ps
module tri_mean_filter
  import fma_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int COEF   = 85,
  parameter int COEF_W = 7,
  parameter int SHIFT  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] sample_in,
  input  logic [1:0]        tag_in,
  output logic [DATA_W-1:0] mean_out,
  output logic [1:0]        tag_out
);
  localparam int SUM_W = DATA_W + $clog2(TAPS + 1);

  logic [TAPS*DATA_W-1:0] taps_w;
  logic [SUM_W-1:0]       sum_w;
  logic [DATA_W-1:0]      mean_w;

  fma_history #(.DATA_W(DATA_W), .NTAPS(TAPS)) u_hist (
    .clk       (clk),
    .rst_n     (rst_n),
    .sample_in (sample_in),
    .tag_in    (tag_in),
    .taps_o    (taps_w)
  );

  fma_scale #(
    .DATA_W(DATA_W), .NTAPS(TAPS), .COEF(COEF), .COEF_W(COEF_W), .SHIFT(SHIFT)
  ) u_scale (
    .taps_i (taps_w),
    .sum_o  (sum_w),
    .mean_o (mean_w)
  );

  // tag travels alongside the history stage, then the output stage
  logic [1:0]        tag_mid_q;
  logic [1:0]        tag_out_q;
  logic [DATA_W-1:0] mean_q;
  logic              load_w;
  logic              run_q;

  assign load_w = tag_valid(tag_mid_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tag_mid_q <= TAG_IDLE;
      tag_out_q <= TAG_IDLE;
      mean_q    <= '0;
      run_q     <= 1'b0;
    end else begin
      tag_mid_q <= tag_in;
      tag_out_q <= tag_mid_q;
      run_q     <= 1'b1;
      if (load_w) mean_q <= mean_w;
    end
  end

  assign mean_out = mean_q;
  assign tag_out  = tag_out_q;

  // R1: reset clears the outputs
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (mean_out == '0 && tag_out == TAG_IDLE));

  // R6: tag delay, first stage then second stage
  assert_tag_mid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (tag_mid_q == $past(tag_in)));
  assert_tag_out_R6: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (tag_out == $past(tag_mid_q)));

  // R7: idle slot keeps the mean and emits an idle tag
  assert_idle_out_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && tag_mid_q == TAG_IDLE) |=> ($stable(mean_out) && tag_out == TAG_IDLE));

  // R3: the scaled mean never exceeds a true third of the sum
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(mean_w) * TAPS) <= 32'(sum_w));
endmodule

// File: tb/sim_tri_mean_filter.sv
`timescale 1ns/1ps
module sim_tri_mean_filter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] sample_in = '0;
  logic [1:0] tag_in = 2'b00;
  logic [7:0] mean_out;
  logic [1:0] tag_out;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // model state
  int hist [3];
  int last_mean = 0;
  logic [1:0] prev_tag = 2'b00;
  int prev_mean = 0;

  always #4 clk = ~clk;

  tri_mean_filter u0 (
    .clk(clk), .rst_n(rst_n), .sample_in(sample_in), .tag_in(tag_in),
    .mean_out(mean_out), .tag_out(tag_out)
  );

  function automatic int ref_mean(input int a, input int b, input int c);
    return ((a + b + c) * 85) / 256;
  endfunction

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // present one input for one cycle; compare the outputs due from the previous call
  task automatic step(input logic [1:0] t, input int s, input string req);
    int m;
    if (t == 2'b01) begin
      hist[2] = 0; hist[1] = 0; hist[0] = s;
    end else if (t != 2'b00) begin
      hist[2] = hist[1]; hist[1] = hist[0]; hist[0] = s;
    end
    if (t != 2'b00) begin
      m = ref_mean(hist[0], hist[1], hist[2]);
      last_mean = m;
    end else begin
      m = last_mean;
    end
    tag_in = t;
    sample_in = 8'(s);
    @(negedge clk);
    check("R6", int'(tag_out), int'(prev_tag), "tag");
    check(req, int'(mean_out), prev_mean, "mean");
    prev_tag = t;
    prev_mean = m;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    tag_in = 2'b00;
    sample_in = 8'hA5;
    @(negedge clk);
    @(negedge clk);
    check("R1", int'(mean_out), 0, "mean in reset");
    check("R1", int'(tag_out), 0, "tag in reset");
    rst_n = 1'b1;
    hist[0] = 0; hist[1] = 0; hist[2] = 0;
    last_mean = 0; prev_tag = 2'b00; prev_mean = 0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk);
    do_reset();

    // R1: inner sample straight after reset sees zero history: 90*85/256 = 29
    step(2'b10, 90, "R1");
    step(2'b00, 0, "R1");
    check("R1", int'(mean_out), 29, "mean after reset");

    // R8: directed frame, means 33 49 116 149 199 172
    step(2'b01, 100, "R8");
    step(2'b10, 50, "R8");
    step(2'b10, 200, "R8");
    step(2'b10, 200, "R8");
    step(2'b10, 200, "R8");
    step(2'b11, 120, "R8");
    step(2'b00, 0, "R8");
    check("R8", int'(mean_out), 172, "closing mean");
    step(2'b00, 0, "R7");
    check("R7", int'(mean_out), 172, "held mean");
    check("R7", int'(tag_out), 0, "idle tag");

    // R4: back-to-back frames: closing then opening in consecutive cycles
    step(2'b01, 250, "R4");
    step(2'b11, 250, "R4");
    step(2'b01, 30, "R4");
    step(2'b10, 60, "R4");
    step(2'b00, 0, "R4");
    check("R4", int'(mean_out), ref_mean(30, 60, 0), "mean after reopen");

    // R3: full scale
    step(2'b01, 255, "R3");
    step(2'b10, 255, "R3");
    step(2'b11, 255, "R3");
    step(2'b00, 0, "R3");
    check("R3", int'(mean_out), 254, "full scale mean");

    // R5: idle cycles inside a frame
    step(2'b01, 10, "R5");
    step(2'b00, 0, "R5");
    step(2'b00, 0, "R5");
    step(2'b10, 20, "R5");
    step(2'b00, 0, "R5");
    step(2'b10, 40, "R5");
    step(2'b00, 0, "R5");
    check("R5", int'(mean_out), ref_mean(10, 20, 40), "mean across idles");

    // R2: random tags and samples against the reference
    for (int i = 0; i < 4000; i++) begin
      int r;
      logic [1:0] t;
      r = int'($urandom % 8);
      if (r < 2)      t = 2'b00;
      else if (r == 2) t = 2'b01;
      else if (r < 7)  t = 2'b10;
      else             t = 2'b11;
      step(t, int'($urandom % 256), "R2");
    end

    // R1: reset in mid-stream, then an inner sample sees zero history
    step(2'b10, 77, "R1");
    do_reset();
    step(2'b10, 200, "R1");
    step(2'b00, 0, "R1");
    check("R1", int'(mean_out), ref_mean(200, 0, 0), "mean after mid reset");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule